// File: doc/BRIEF.md
# Serial Programming Command Decoder

This block is the target-side command engine of a serial programming port. It assembles 8-bit commands from a bit-serial stream, recognises them, and carries each one out. It keeps the programming address counter (PC) and issues single requests to a memory controller: latch a data word, read a word, erase a row, erase in bulk, and start or stop a programming cycle. Commands that carry a 24-bit payload hand it over through a word-level handshake with a separate payload framer. The decoder only sees the extracted address or data word, or it supplies the word to be shifted out.

While a payload, a memory operation or an outgoing word is pending, the decoder owns no serial bits. The framer or the memory controller finishes the transfer, and then the decoder listens for the next command. The read path returns zeros whenever code protection is active. Opcodes outside the supported set are dropped and set a sticky error flag.

Top module: `prog_cmd_decoder`

## Requirements
- R1: A command is 8 bits taken from `ser_bit_i` on cycles with `ser_valid_i` high, first bit as the MSb. Serial bits that arrive while the decoder is not idle are ignored.
- R2: Opcode 0x80 raises `pl_rx_ready_o`. The word accepted on `pl_rx_valid_i` becomes the new PC, and no memory request is issued.
- R3: Opcodes 0x00 and 0x02 wait for one received word. They then issue one latch request (`mem_op_o`=0) at the current PC with `mem_wdata_o` equal to the low 14 bits of that word. Opcode 0x02 then advances the PC by one (modulo 2^22), and 0x00 leaves it unchanged.
- R4: Opcodes 0xFC and 0xFE issue one read request (`mem_op_o`=1) at the PC. The returned word is offered on `pl_tx_data_o` with `pl_tx_valid_o` until `pl_tx_ready_i`. Opcode 0xFE advances the PC by one after that handshake, and 0xFC does not.
- R5: When `cp_i` is high in the cycle the read completes, the offered word is zero.
- R6: Opcode 0xF8 advances the PC by one. It has no payload and issues no memory request.
- R7: Opcode 0xF0 issues a row erase (`mem_op_o`=2). Its address is the PC with bits [4:0] cleared, and the PC is unchanged.
- R8: Opcodes 0x18, 0xE0, 0xC0 and 0x82 issue bulk erase (3), start self-timed programming (4), start externally timed programming (5) and stop externally timed programming (6), each at the PC, with the PC unchanged.
- R9: Any other opcode sets `err_o`, which stays set until reset. It causes no PC change, no payload phase and no memory request.
- R10: `mem_req_o` is a one-cycle pulse, issued once per command. `busy_o` is high from that pulse until the cycle after `mem_done_i`.
- R11: After reset the PC is 0, and `busy_o`, `err_o`, `mem_req_o`, `pl_rx_ready_o` and `pl_tx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_valid_i | input | 1 | Serial bit strobe |
| ser_bit_i | input | 1 | Serial command bit |
| pl_rx_valid_i | input | 1 | Received payload word valid |
| pl_rx_data_i | input | 22 | Received payload word |
| pl_rx_ready_o | output | 1 | Decoder waits for a payload word |
| pl_tx_valid_o | output | 1 | Outgoing payload word valid |
| pl_tx_data_o | output | 14 | Outgoing payload word |
| pl_tx_ready_i | input | 1 | Framer took the outgoing word |
| cp_i | input | 1 | Code protection active |
| mem_req_o | output | 1 | Memory request pulse |
| mem_op_o | output | 3 | Memory operation code |
| mem_addr_o | output | 22 | Memory request address |
| mem_wdata_o | output | 14 | Word for the data latch |
| mem_done_i | input | 1 | Memory operation finished |
| mem_rdata_i | input | 14 | Read word, valid with done |
| busy_o | output | 1 | Memory operation pending |
| err_o | output | 1 | Sticky unknown-opcode flag |
| pc_o | output | 22 | Current program counter |

## Verification
On every cycle, the assertions check the memory handshake: each request pulse is single and covered by busy, and busy drops after done. They also check the row alignment of erase addresses, the zeroing of read data under protection, the persistence of the error flag, and that the receive and send phases never overlap. Only the bench's scenarios can show that each of the 256 opcodes, with protection both on and off, produces the right PC, request, address, write word and payload traffic. The same holds for the fact that serial bits arriving during a long operation are dropped.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;

  typedef enum logic [2:0] {
    MOP_LATCH      = 3'd0,
    MOP_READ       = 3'd1,
    MOP_ROW_ERASE  = 3'd2,
    MOP_BULK_ERASE = 3'd3,
    MOP_PROG_INT   = 3'd4,
    MOP_PROG_EXT_B = 3'd5,
    MOP_PROG_EXT_E = 3'd6
  } mem_op_e;

  typedef enum logic [3:0] {
    CK_NONE,
    CK_LOAD_PC,
    CK_LOAD,
    CK_READ,
    CK_INC,
    CK_ROW_ERASE,
    CK_BULK_ERASE,
    CK_PROG_INT,
    CK_PROG_EXT_B,
    CK_PROG_EXT_E
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      post_inc;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_MEM, ST_TX} dec_state_e;

endpackage

// File: rtl/prog_cmd_shift.sv
module prog_cmd_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-2:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take        = en_i && bit_valid_i;
  assign cmd_valid_o = take && (cnt_q == CNT_W'(CMD_W-1));
  assign cmd_o       = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= {sh_q[CMD_W-3:0], bit_i};
      cnt_q <= cmd_valid_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/prog_cmd_decode.sv
module prog_cmd_decode
  import prog_cmd_pkg::*;
(
  input  logic [7:0] opc_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.post_inc = 1'b0;
    unique case (opc_i)
      8'h80:   cmd_o.kind = CK_LOAD_PC;
      8'h00:   cmd_o.kind = CK_LOAD;
      8'h02: begin
        cmd_o.kind     = CK_LOAD;
        cmd_o.post_inc = 1'b1;
      end
      8'hFC:   cmd_o.kind = CK_READ;
      8'hFE: begin
        cmd_o.kind     = CK_READ;
        cmd_o.post_inc = 1'b1;
      end
      8'hF8:   cmd_o.kind = CK_INC;
      8'hF0:   cmd_o.kind = CK_ROW_ERASE;
      8'h18:   cmd_o.kind = CK_BULK_ERASE;
      8'hE0:   cmd_o.kind = CK_PROG_INT;
      8'hC0:   cmd_o.kind = CK_PROG_EXT_B;
      8'h82:   cmd_o.kind = CK_PROG_EXT_E;
      default: cmd_o.kind = CK_NONE;
    endcase
  end
endmodule

// File: rtl/prog_pc_unit.sv
module prog_pc_unit #(
  parameter int PC_W = 22
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_val_i,
  input  logic            inc_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_o <= '0;
    else if (load_i) pc_o <= load_val_i;
    else if (inc_i)  pc_o <= pc_o + 1'b1;
  end
endmodule

// File: rtl/prog_cmd_decoder.sv
module prog_cmd_decoder
  import prog_cmd_pkg::*;
#(
  parameter int PC_W   = 22,
  parameter int DATA_W = 14,
  parameter int ROW_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_valid_i,
  input  logic              ser_bit_i,
  input  logic              pl_rx_valid_i,
  input  logic [PC_W-1:0]   pl_rx_data_i,
  output logic              pl_rx_ready_o,
  output logic              pl_tx_valid_o,
  output logic [DATA_W-1:0] pl_tx_data_o,
  input  logic              pl_tx_ready_i,
  input  logic              cp_i,
  output logic              mem_req_o,
  output logic [2:0]        mem_op_o,
  output logic [PC_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_done_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              err_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int CMD_W = 8;
  localparam logic [PC_W-1:0] ROW_MASK = {{(PC_W-ROW_W){1'b1}}, {ROW_W{1'b0}}};

  dec_state_e        state_q, state_d;
  cmd_kind_e         kind_q, kind_d;
  logic              inc_q, inc_d;
  logic              cmd_valid;
  logic [CMD_W-1:0]  opc;
  cmd_t              dec;
  logic              pc_load, pc_inc;
  logic              issue;
  mem_op_e           issue_op;
  logic [PC_W-1:0]   issue_addr;
  logic [DATA_W-1:0] issue_wdata;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              req_q;
  mem_op_e           op_q;
  logic [PC_W-1:0]   addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q;

  prog_cmd_shift #(.CMD_W(CMD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (state_q == ST_IDLE),
    .bit_valid_i (ser_valid_i),
    .bit_i       (ser_bit_i),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (opc)
  );

  prog_cmd_decode u_decode (
    .opc_i (opc),
    .cmd_o (dec)
  );

  prog_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (pc_load),
    .load_val_i (pl_rx_data_i),
    .inc_i      (pc_inc),
    .pc_o       (pc_o)
  );

  always_comb begin
    state_d     = state_q;
    kind_d      = kind_q;
    inc_d       = inc_q;
    tx_d        = tx_q;
    pc_load     = 1'b0;
    pc_inc      = 1'b0;
    issue       = 1'b0;
    issue_op    = MOP_LATCH;
    issue_addr  = pc_o;
    issue_wdata = wdata_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        kind_d = dec.kind;
        inc_d  = dec.post_inc;
        unique case (dec.kind)
          CK_LOAD_PC, CK_LOAD: state_d = ST_RX;
          CK_READ: begin
            issue    = 1'b1;
            issue_op = MOP_READ;
          end
          CK_INC: pc_inc = 1'b1;
          CK_ROW_ERASE: begin
            issue      = 1'b1;
            issue_op   = MOP_ROW_ERASE;
            issue_addr = pc_o & ROW_MASK;
          end
          CK_BULK_ERASE: begin
            issue    = 1'b1;
            issue_op = MOP_BULK_ERASE;
          end
          CK_PROG_INT: begin
            issue    = 1'b1;
            issue_op = MOP_PROG_INT;
          end
          CK_PROG_EXT_B: begin
            issue    = 1'b1;
            issue_op = MOP_PROG_EXT_B;
          end
          CK_PROG_EXT_E: begin
            issue    = 1'b1;
            issue_op = MOP_PROG_EXT_E;
          end
          default: ;
        endcase
        if (issue) state_d = ST_MEM;
      end
      ST_RX: if (pl_rx_valid_i) begin
        if (kind_q == CK_LOAD_PC) begin
          pc_load = 1'b1;
          state_d = ST_IDLE;
        end else begin
          issue       = 1'b1;
          issue_op    = MOP_LATCH;
          issue_wdata = pl_rx_data_i[DATA_W-1:0];
          pc_inc      = inc_q;
          state_d     = ST_MEM;
        end
      end
      ST_MEM: if (mem_done_i) begin
        if (kind_q == CK_READ) begin
          tx_d    = cp_i ? '0 : mem_rdata_i;
          state_d = ST_TX;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_TX: if (pl_tx_ready_i) begin
        pc_inc  = inc_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= CK_NONE;
      inc_q   <= 1'b0;
      tx_q    <= '0;
      req_q   <= 1'b0;
      op_q    <= MOP_LATCH;
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      inc_q   <= inc_d;
      tx_q    <= tx_d;
      req_q   <= issue;
      if (issue) begin
        op_q    <= issue_op;
        addr_q  <= issue_addr;
        wdata_q <= issue_wdata;
      end
      if (state_q == ST_IDLE && cmd_valid && dec.kind == CK_NONE) err_q <= 1'b1;
    end
  end

  assign pl_rx_ready_o = (state_q == ST_RX);
  assign pl_tx_valid_o = (state_q == ST_TX);
  assign pl_tx_data_o  = tx_q;
  assign mem_req_o     = req_q;
  assign mem_op_o      = op_q;
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = wdata_q;
  assign busy_o        = (state_q == ST_MEM);
  assign err_o         = err_q;
endmodule

// File: rtl/prog_cmd_decoder_chk.sv
module prog_cmd_decoder_chk #(
  parameter int PC_W   = 22,
  parameter int DATA_W = 14,
  parameter int ROW_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cp_i,
  input logic              mem_req_o,
  input logic [2:0]        mem_op_o,
  input logic [PC_W-1:0]   mem_addr_o,
  input logic              mem_done_i,
  input logic              busy_o,
  input logic              err_o,
  input logic              pl_rx_ready_o,
  input logic              pl_tx_valid_o,
  input logic [DATA_W-1:0] pl_tx_data_o
);
  // R10
  req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R10
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R10
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_done_i) |=> !busy_o);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R7
  row_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_op_o == 3'd2) |-> (mem_addr_o[ROW_W-1:0] == '0));
  // R5
  cp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_done_i && cp_i && mem_op_o == 3'd1)
      |=> (pl_tx_valid_o && pl_tx_data_o == '0));
  // R2
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pl_rx_ready_o && pl_tx_valid_o));
endmodule

bind prog_cmd_decoder prog_cmd_decoder_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .ROW_W(ROW_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cp_i          (cp_i),
  .mem_req_o     (mem_req_o),
  .mem_op_o      (mem_op_o),
  .mem_addr_o    (mem_addr_o),
  .mem_done_i    (mem_done_i),
  .busy_o        (busy_o),
  .err_o         (err_o),
  .pl_rx_ready_o (pl_rx_ready_o),
  .pl_tx_valid_o (pl_tx_valid_o),
  .pl_tx_data_o  (pl_tx_data_o)
);

// File: tb/prog_cmd_decoder_bench.sv
module prog_cmd_decoder_bench;
  localparam int PC_W = 22;
  localparam int DW   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_valid = 1'b0, ser_bit = 1'b0;
  logic rx_valid = 1'b0;
  logic [PC_W-1:0] rx_data = '0;
  logic rx_ready, tx_valid;
  logic [DW-1:0] tx_data;
  logic tx_ready = 1'b0;
  logic cp = 1'b0;
  logic mem_req;
  logic [2:0] mem_op;
  logic [PC_W-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_done = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic busy, err;
  logic [PC_W-1:0] pc;

  int checks = 0, fails = 0;
  int lat = 3;
  int req_cnt = 0, rx_cnt = 0, tx_cnt = 0;
  int cnt = 0;
  logic [2:0] rec_op = '0;
  logic [PC_W-1:0] rec_addr = '0;
  logic [DW-1:0] rec_wdata = '0, rec_tx = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  prog_cmd_decoder u_prog_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ser_valid_i(ser_valid), .ser_bit_i(ser_bit),
    .pl_rx_valid_i(rx_valid), .pl_rx_data_i(rx_data), .pl_rx_ready_o(rx_ready),
    .pl_tx_valid_o(tx_valid), .pl_tx_data_o(tx_data), .pl_tx_ready_i(tx_ready),
    .cp_i(cp), .mem_req_o(mem_req), .mem_op_o(mem_op), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_done_i(mem_done), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .err_o(err), .pc_o(pc)
  );

  // behavioural memory: done after lat cycles, read word derived from address
  assign mem_rdata = rec_addr[DW-1:0] ^ 14'h2a5;
  always @(posedge clk) begin
    mem_done <= 1'b0;
    if (mem_req) begin
      req_cnt++;
      rec_op    <= mem_op;
      rec_addr  <= mem_addr;
      rec_wdata <= mem_wdata;
      cnt       <= lat;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) mem_done <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      ser_valid = 1'b1;
      ser_bit   = b[i];
    end
    @(negedge clk);
    ser_valid = 1'b0;
  endtask

  // services payload handshakes for a number of cycles
  task automatic serve(input int cycles, input logic [PC_W-1:0] d);
    for (int i = 0; i < cycles; i++) begin
      rx_valid = 1'b0;
      tx_ready = 1'b0;
      if (rx_ready) begin
        rx_valid = 1'b1;
        rx_data  = d;
        rx_cnt++;
      end
      if (tx_valid) begin
        tx_ready = 1'b1;
        rec_tx   = tx_data;
        tx_cnt++;
      end
      @(negedge clk);
    end
    rx_valid = 1'b0;
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R11 reset state
    chk(pc == 0, "R11 pc", 32'(pc), 0);
    chk(!busy && !err && !mem_req, "R11 busy/err/req", {busy, err, mem_req}, 0);
    chk(!rx_ready && !tx_valid, "R11 payload", {rx_ready, tx_valid}, 0);

    for (int c = 0; c < 2; c++) begin
      for (int op = 0; op < 256; op++) begin
        logic [7:0] o;
        logic [PC_W-1:0] v, d, e_pc, e_addr;
        logic [2:0] e_op;
        bit e_req, e_rx, e_tx, e_err, known, j;
        logic [DW-1:0] e_tx_data;
        int r0, rx0, tx0;
        o = 8'(op);
        v = (o & 8'h04) ? 22'h3fffff - 22'(op) : 22'(op * 40503 + 4660 + c * 77);
        d = 22'(op * 7919 + 88666);
        cp = c[0];
        do_reset();
        send_byte(8'h80);
        serve(6, v);
        chk(pc == v, "R2 load pc", 32'(pc), 32'(v));
        r0 = req_cnt; rx0 = rx_cnt; tx0 = tx_cnt;
        send_byte(o);
        serve(40, d);
        // expected behaviour per R2..R9
        j = o[1];
        known = 1; e_req = 1; e_rx = 0; e_tx = 0; e_pc = v; e_addr = v; e_op = 0;
        e_tx_data = c ? '0 : (v[DW-1:0] ^ 14'h2a5);
        case (o)
          8'h80: begin e_req = 0; e_rx = 1; e_pc = d; end
          8'h00, 8'h02: begin e_rx = 1; e_op = 0; e_pc = v + 22'(j); end
          8'hFC, 8'hFE: begin e_tx = 1; e_op = 1; e_pc = v + 22'(j); end
          8'hF8: begin e_req = 0; e_pc = v + 1; end
          8'hF0: begin e_op = 2; e_addr = v & ~22'h1f; end
          8'h18: e_op = 3;
          8'hE0: e_op = 4;
          8'hC0: e_op = 5;
          8'h82: e_op = 6;
          default: begin known = 0; e_req = 0; end
        endcase
        e_err = !known;
        chk(pc == e_pc, "R3/R4/R6/R9 pc after command", 32'(pc), 32'(e_pc));
        chk(err == e_err, "R9 err flag", 32'(err), 32'(e_err));
        chk((req_cnt - r0) == int'(e_req), "R10 request count", req_cnt - r0, 32'(e_req));
        chk((rx_cnt - rx0) == int'(e_rx), "R2/R3 rx payload", rx_cnt - rx0, 32'(e_rx));
        chk((tx_cnt - tx0) == int'(e_tx), "R4 tx payload", tx_cnt - tx0, 32'(e_tx));
        if (e_req) begin
          chk(rec_op == e_op, "R7/R8 mem op", 32'(rec_op), 32'(e_op));
          chk(rec_addr == e_addr, "R7/R8 mem addr", 32'(rec_addr), 32'(e_addr));
        end
        if (e_rx && e_req)
          chk(rec_wdata == d[DW-1:0], "R3 latch data", 32'(rec_wdata), 32'(d[DW-1:0]));
        if (e_tx)
          chk(rec_tx == e_tx_data, "R4/R5 read data", 32'(rec_tx), 32'(e_tx_data));
        chk(!busy, "R10 idle at end", 32'(busy), 0);
      end
    end

    // R1/R10: bits sent during a long operation are ignored
    cp = 1'b0;
    lat = 30;
    do_reset();
    send_byte(8'h80);
    serve(6, 22'h100);
    send_byte(8'h18);
    chk(busy, "R10 busy while pending", 32'(busy), 1);
    send_byte(8'hF8);
    chk(busy, "R10 busy held until done", 32'(busy), 1);
    serve(40, 22'h0);
    chk(pc == 22'h100, "R1 bits during busy ignored", 32'(pc), 32'h100);
    chk(!err, "R1 no error from ignored bits", 32'(err), 0);
    // R1: after release, the next full byte is decoded again
    lat = 3;
    send_byte(8'hF8);
    serve(4, 22'h0);
    chk(pc == 22'h101, "R1 decode after release", 32'(pc), 32'h101);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule